// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block decides which of a parameterised group of interrupt agents a message is aimed at. The sender supplies a destination byte, a bit that chooses physical or logical addressing, a two-bit shorthand code and its own agent index. Each agent publishes three values that it keeps for itself: its physical ID, its logical destination byte and a 4-bit destination model. The block combines these inputs into a multi-hot agent mask.

For lowest-priority delivery the block also gives a second mask that keeps only one target. The block is purely combinational, so both masks follow their inputs within the same cycle. The agent tables are flat parallel vectors, with agent `i` in slice `i`. The block does not arbitrate between agents on priority and does not deliver the message.

Top module: `irq_dest_resolver`

## Requirements
- R1: With physical addressing (`logical_mode`=0), shorthand 0 and a destination of all ones, `full_mask` has every agent bit set, whatever the agent IDs are.
- R2: With physical addressing, shorthand 0 and any other destination, `full_mask` selects the agent whose physical ID equals the destination. If no agent matches, `full_mask` is all zeros.
- R3: With physical addressing, if several agents share the addressed ID, only the lowest-index one of them is selected.
- R4: With logical addressing (`logical_mode`=1) and shorthand 0, an agent whose model is 4'hF (flat) is selected when the destination ANDed with its logical byte is nonzero.
- R5: With logical addressing and shorthand 0, an agent whose model is 4'h0 (cluster) is selected when the upper halves of the destination and its logical byte are equal and their lower halves share a set bit. A destination with a zero lower half selects no cluster agent.
- R6: With logical addressing, an agent whose model is neither 4'hF nor 4'h0 is never selected.
- R7: The shorthand codes work as follows. 0 uses the addressing fields. 1 selects only the sender. 2 selects every agent. 3 selects every agent except the sender. Codes 1 to 3 ignore the destination and the mode bit.
- R8: A sender index at or above the agent count selects nobody under shorthand 1, and under shorthand 3 it leaves every agent selected.
- R9: `first_mask` holds only the lowest-index set bit of `full_mask`. It is all zeros when `full_mask` is empty.
- R10: The agent tables are live inputs. Changing an agent's model or byte changes the masks in the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dest_id | input | DEST_W | Destination byte from the message |
| logical_mode | input | 1 | 0 selects physical addressing, 1 selects logical addressing |
| shorthand | input | 2 | Shorthand code: 0 addressed, 1 self, 2 all, 3 all but self |
| sender_idx | input | IDX_W | Index of the sending agent |
| agent_phys_id | input | N_AGENTS*DEST_W | Physical ID of each agent |
| agent_log_dest | input | N_AGENTS*DEST_W | Logical destination byte of each agent |
| agent_model | input | N_AGENTS*4 | Destination model of each agent |
| full_mask | output | N_AGENTS | Every selected agent |
| first_mask | output | N_AGENTS | Lowest-index selected agent only (lowest-priority target) |

## Verification
The bench builds the block with six agents and an 8-bit destination. Six agents leave the 3-bit sender index with two codes that name no agent, so the out-of-range sender cases of R8 can be reached. The agent table is chosen so that two agents share a physical ID, one agent has an unused model value whose logical byte would otherwise match, and the flat and cluster agents overlap in their logical bytes. With this table a single destination can exercise several matching rules at once.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int MODEL_W = 4;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_ADDRESSED = 2'd0,
    SH_SELF      = 2'd1,
    SH_ALL       = 2'd2,
    SH_OTHERS    = 2'd3
  } shorthand_e;
endpackage

// File: rtl/lowest_bit_pick.sv
module lowest_bit_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_in,
  output logic [W-1:0] vec_out
);
  // Two's complement isolates the least significant set bit.
  always_comb begin
    vec_out = vec_in & (~vec_in + W'(1));
  end

  always_comb begin
    // R9
    pick_onehot_chk: assert ($onehot0(vec_out)) else $error("pick not one-hot");
    // R9
    pick_subset_chk: assert ((vec_out & ~vec_in) == '0) else $error("pick outside input");
    // R9
    pick_nonempty_chk: assert ((vec_in == '0) || (vec_out != '0)) else $error("pick lost a bit");
  end
endmodule

// File: rtl/phys_match.sv
module phys_match #(
  parameter int N_AGENTS = 8,
  parameter int DEST_W   = 8
) (
  input  logic [DEST_W-1:0]          dest_id,
  input  logic [N_AGENTS*DEST_W-1:0] agent_phys_id,
  output logic [N_AGENTS-1:0]        sel
);
  localparam logic [DEST_W-1:0] BCAST_ID = '1;

  logic [N_AGENTS-1:0] id_hit;
  logic [N_AGENTS-1:0] id_first;
  logic                is_bcast;

  for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_cmp
    assign id_hit[gi] = (agent_phys_id[gi*DEST_W +: DEST_W] == dest_id);
  end

  // Duplicate IDs resolve to the lowest index holding the ID.
  lowest_bit_pick #(.W(N_AGENTS)) u_dup_pick (
    .vec_in  (id_hit),
    .vec_out (id_first)
  );

  always_comb begin
    is_bcast = (dest_id == BCAST_ID);
    sel      = is_bcast ? '1 : id_first;
  end

  always_comb begin
    // R2
    phys_single_chk: assert (is_bcast || ($countones(sel) <= 1)) else $error("physical hit not unique");
    // R2
    phys_hit_chk: assert (is_bcast || ((sel & ~id_hit) == '0)) else $error("physical sel without id match");
  end
endmodule

// File: rtl/logic_match.sv
module logic_match
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int DEST_W   = 8
) (
  input  logic [DEST_W-1:0]           dest_id,
  input  logic [N_AGENTS*DEST_W-1:0]  agent_log_dest,
  input  logic [N_AGENTS*MODEL_W-1:0] agent_model,
  output logic [N_AGENTS-1:0]         sel
);
  localparam int HALF_W = DEST_W / 2;

  for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_agent
    logic [DEST_W-1:0]  ldest;
    logic [MODEL_W-1:0] model;
    logic               flat_hit;
    logic               clus_hit;

    always_comb begin
      ldest    = agent_log_dest[gi*DEST_W +: DEST_W];
      model    = agent_model[gi*MODEL_W +: MODEL_W];
      flat_hit = |(dest_id & ldest);
      clus_hit = (dest_id[DEST_W-1:HALF_W] == ldest[DEST_W-1:HALF_W]) &&
                 (|(dest_id[HALF_W-1:0] & ldest[HALF_W-1:0]));
      unique case (model)
        MODEL_FLAT:    sel[gi] = flat_hit;
        MODEL_CLUSTER: sel[gi] = clus_hit;
        default:       sel[gi] = 1'b0;
      endcase
    end

    always_comb begin
      // R6
      logic_model_chk: assert (!sel[gi] || (model == MODEL_FLAT) || (model == MODEL_CLUSTER))
        else $error("agent with unused model selected");
      // R4
      logic_overlap_chk: assert (!sel[gi] || (|(dest_id & ldest)))
        else $error("logical sel without shared bit");
    end
  end
endmodule

// File: rtl/shorthand_sel.sv
module shorthand_sel
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [1:0]          shorthand,
  input  logic [IDX_W-1:0]    sender_idx,
  input  logic [N_AGENTS-1:0] addressed,
  output logic [N_AGENTS-1:0] sel
);
  logic [N_AGENTS-1:0] self_vec;
  shorthand_e          sh;

  for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_self
    assign self_vec[gi] = (sender_idx == IDX_W'(gi));
  end

  always_comb begin
    sh = shorthand_e'(shorthand);
    unique case (sh)
      SH_ADDRESSED: sel = addressed;
      SH_SELF:      sel = self_vec;
      SH_ALL:       sel = '1;
      SH_OTHERS:    sel = ~self_vec;
      default:      sel = '0;
    endcase
  end

  always_comb begin
    // R7
    sh_others_chk: assert ((sh != SH_OTHERS) || ((sel & self_vec) == '0)) else $error("sender kept in others");
    // R7
    sh_self_chk: assert ((sh != SH_SELF) || ($countones(sel) <= 1)) else $error("self selects many");
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int DEST_W   = 8,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [DEST_W-1:0]           dest_id,
  input  logic                        logical_mode,
  input  logic [1:0]                  shorthand,
  input  logic [IDX_W-1:0]            sender_idx,
  input  logic [N_AGENTS*DEST_W-1:0]  agent_phys_id,
  input  logic [N_AGENTS*DEST_W-1:0]  agent_log_dest,
  input  logic [N_AGENTS*MODEL_W-1:0] agent_model,
  output logic [N_AGENTS-1:0]         full_mask,
  output logic [N_AGENTS-1:0]         first_mask
);
  logic [N_AGENTS-1:0] phys_sel;
  logic [N_AGENTS-1:0] log_sel;
  logic [N_AGENTS-1:0] addr_sel;

  phys_match #(.N_AGENTS(N_AGENTS), .DEST_W(DEST_W)) u_phys (
    .dest_id       (dest_id),
    .agent_phys_id (agent_phys_id),
    .sel           (phys_sel)
  );

  logic_match #(.N_AGENTS(N_AGENTS), .DEST_W(DEST_W)) u_logic (
    .dest_id        (dest_id),
    .agent_log_dest (agent_log_dest),
    .agent_model    (agent_model),
    .sel            (log_sel)
  );

  always_comb begin
    addr_sel = logical_mode ? log_sel : phys_sel;
  end

  shorthand_sel #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_short (
    .shorthand  (shorthand),
    .sender_idx (sender_idx),
    .addressed  (addr_sel),
    .sel        (full_mask)
  );

  lowest_bit_pick #(.W(N_AGENTS)) u_lowpri (
    .vec_in  (full_mask),
    .vec_out (first_mask)
  );

  always_comb begin
    // R9
    first_in_full_chk: assert ((first_mask & ~full_mask) == '0) else $error("first not in full");
    // R7
    all_code_chk: assert ((shorthand != 2'd2) || (&full_mask)) else $error("all code incomplete");
  end
endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;
  localparam int N  = 6;
  localparam int DW = 8;
  localparam int IW = 3;

  logic clk;
  logic rst_n;
  logic [DW-1:0]   dest_id;
  logic            logical_mode;
  logic [1:0]      shorthand;
  logic [IW-1:0]   sender_idx;
  logic [N*DW-1:0] agent_phys_id;
  logic [N*DW-1:0] agent_log_dest;
  logic [N*4-1:0]  agent_model;
  logic [N-1:0]    full_mask;
  logic [N-1:0]    first_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_dest_resolver #(.N_AGENTS(N), .DEST_W(DW)) u_irq_dest_resolver (
    .dest_id        (dest_id),
    .logical_mode   (logical_mode),
    .shorthand      (shorthand),
    .sender_idx     (sender_idx),
    .agent_phys_id  (agent_phys_id),
    .agent_log_dest (agent_log_dest),
    .agent_model    (agent_model),
    .full_mask      (full_mask),
    .first_mask     (first_mask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic lm, input logic [DW-1:0] d, input logic [1:0] sh, input logic [IW-1:0] s);
    @(negedge clk);
    logical_mode = lm;
    dest_id      = d;
    shorthand    = sh;
    sender_idx   = s;
    #1;
  endtask

  task automatic set_agent(input int i, input logic [DW-1:0] pid, input logic [DW-1:0] ld, input logic [3:0] m);
    agent_phys_id[i*DW +: DW]  = pid;
    agent_log_dest[i*DW +: DW] = ld;
    agent_model[i*4 +: 4]      = m;
  endtask

  task automatic t_quiet;
    apply(1'b1, 8'h00, 2'd0, 3'd0);
    check("R4 zero logical dest full", full_mask, 6'b000000);
    check("R9 empty full gives empty first", first_mask, 6'b000000);
  endtask

  task automatic t_physical;
    apply(1'b0, 8'hFF, 2'd0, 3'd0);
    check("R1 broadcast full", full_mask, 6'b111111);
    check("R9 broadcast first", first_mask, 6'b000001);
    apply(1'b0, 8'h05, 2'd0, 3'd0);
    check("R2 id 05", full_mask, 6'b001000);
    apply(1'b0, 8'h10, 2'd0, 3'd0);
    check("R2 id 10", full_mask, 6'b000001);
    apply(1'b0, 8'h77, 2'd0, 3'd0);
    check("R2 no match", full_mask, 6'b000000);
    apply(1'b0, 8'h22, 2'd0, 3'd0);
    check("R3 duplicate id", full_mask, 6'b000010);
  endtask

  task automatic t_logical;
    apply(1'b1, 8'h03, 2'd0, 3'd0);
    check("R4 flat dest 03", full_mask, 6'b100011);
    check("R9 first dest 03", first_mask, 6'b000001);
    apply(1'b1, 8'h31, 2'd0, 3'd0);
    check("R5 cluster dest 31", full_mask, 6'b101101);
    apply(1'b1, 8'h32, 2'd0, 3'd0);
    check("R5 cluster dest 32", full_mask, 6'b101010);
    check("R9 first dest 32", first_mask, 6'b000010);
    apply(1'b1, 8'h30, 2'd0, 3'd0);
    check("R5 zero lower half", full_mask, 6'b100000);
    check("R9 first dest 30", first_mask, 6'b100000);
    apply(1'b1, 8'h0C, 2'd0, 3'd0);
    check("R6 unused model excluded", full_mask, 6'b100000);
  endtask

  task automatic t_shorthand;
    apply(1'b0, 8'h05, 2'd1, 3'd2);
    check("R7 self", full_mask, 6'b000100);
    apply(1'b1, 8'h00, 2'd2, 3'd2);
    check("R7 all", full_mask, 6'b111111);
    apply(1'b0, 8'h05, 2'd3, 3'd2);
    check("R7 others", full_mask, 6'b111011);
    apply(1'b0, 8'h77, 2'd3, 3'd0);
    check("R7 others sender0", full_mask, 6'b111110);
    check("R9 first others sender0", first_mask, 6'b000010);
    apply(1'b0, 8'h05, 2'd1, 3'd6);
    check("R8 self out of range", full_mask, 6'b000000);
    apply(1'b0, 8'h05, 2'd3, 3'd7);
    check("R8 others out of range", full_mask, 6'b111111);
  endtask

  task automatic t_live_table;
    apply(1'b1, 8'h0C, 2'd0, 3'd0);
    agent_model[4*4 +: 4] = 4'hF;
    #1;
    check("R10 model change", full_mask, 6'b110000);
    check("R10 first after change", first_mask, 6'b010000);
    agent_log_dest[4*DW +: DW] = 8'h40;
    #1;
    check("R10 byte change", full_mask, 6'b100000);
  endtask

  initial begin
    rst_n = 1'b0;
    dest_id = '0; logical_mode = 1'b1; shorthand = 2'd0; sender_idx = '0;
    agent_phys_id = '0; agent_log_dest = '0; agent_model = '0;
    set_agent(0, 8'h10, 8'h01, 4'hF);
    set_agent(1, 8'h22, 8'h02, 4'hF);
    set_agent(2, 8'h22, 8'h31, 4'h0);
    set_agent(3, 8'h05, 8'h33, 4'h0);
    set_agent(4, 8'h40, 8'h0C, 4'h5);
    set_agent(5, 8'hFF, 8'hFF, 4'hF);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_quiet();
    t_physical();
    t_logical();
    t_shorthand();
    t_live_table();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule